// File: doc/BRIEF.md
# Aliased Set/Clear Control Register

This block holds one 64-bit control word behind a doubleword register bus. Software reaches the word through a small window of three neighbouring doubleword offsets. One offset loads the word outright. The other two change it in one bus cycle without a read-modify-write sequence. In the default variant those two aliases AND the data in and OR the data in. In the second variant, chosen by the `VARIANT` parameter, the window sits at a different base, and the AND alias is replaced by an alias that clears the whole word and ignores the data.

Only the 19 most significant bits of the word are implemented. The most significant bit drives a level interrupt toward an external interrupt controller. A neighbouring engine can pulse `raise_msg` to post a message. The pulse sets the interrupt bit and a shared-memory message flag. Any bus access that lands outside the window, or that is not doubleword-aligned, produces a one-cycle `bad_access` pulse.

Top module: `alias_ctl_reg`

## Requirements
- R1: After reset, the stored word is 0, `irq_level` is 0, `rd_data` is 0 and `bad_access` is 0.
- R2: A write to the direct offset (word offset = byte address >> 3, address bits [2:0] zero) stores the data masked as in R3. A read of the direct offset shows the stored word on `rd_data` on the cycle after the request.
- R3: Only bits [63:45] (bits 0..18 counted MSB-first) are kept. Bits [44:0] are always stored and read as 0.
- R4: With `VARIANT`=0, word offset 0x4020 is the direct offset. 0x4021 stores the old word AND the data, and 0x4022 stores the old word OR the data.
- R5: With `VARIANT`=1, word offset 0x6080 is the direct offset. 0x6081 clears the whole word to 0 whatever the data, and 0x6082 stores the old word OR the data.
- R6: `irq_level` equals bit 63 of the stored word. It follows every update from the cycle after that update, and it does not change when there is no update.
- R7: A `raise_msg` pulse ORs bits 63 and 60 (MSB-first bits 0 and 3) into the stored word.
- R8: When a bus write and `raise_msg` fall in the same cycle, the write is applied first and the raise bits are then ORed into the result.
- R9: Reads of the two alias offsets return 0. Writes to undecoded offsets leave the word unchanged.
- R10: `bad_access` pulses high for one cycle, on the cycle after any request (read or write) whose offset is outside the variant's three-offset window or whose address bits [2:0] are not zero. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (20) | Byte address of the doubleword |
| bus_wdata | input | DATA_W (64) | Write data, bit 63 is MSB-first bit 0 |
| raise_msg | input | 1 | Internal message-raise request |
| rd_data | output | DATA_W (64) | Read data, valid the cycle after a read |
| irq_level | output | 1 | Level interrupt, equal to stored bit 63 |
| bad_access | output | 1 | One-cycle pulse for an undecoded or misaligned access |

## Verification
The assertions check several properties on every cycle. Unimplemented bits never appear on the read port. A raise request always leaves the interrupt high. An OR write with the top bit set raises the interrupt. The interrupt holds steady across idle cycles. The alias reads return zero, the clear or AND-with-zero write drops the interrupt, and the decode-error pulse tracks each out-of-window request. Some behaviours need known data and only the bench's directed scenarios can show them: the exact stored value after each alias operation, the ordering when a write and a raise coincide, the fact that an undecoded write leaves the word unchanged, and the two variants' different windows.

// File: rtl/alias_ctl_pkg.sv
package alias_ctl_pkg;
   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_LOAD  = 3'd1,
      OP_AND   = 3'd2,
      OP_OR    = 3'd3,
      OP_CLEAR = 3'd4
   } alias_op_e;

   // window base word offsets per variant; the alias order inside a window is fixed
   localparam int unsigned WIN_BASE_MASKED = 32'h4020;
   localparam int unsigned WIN_BASE_CLEAR  = 32'h6080;

   function automatic int unsigned win_base(input int unsigned variant);
      return (variant == 0) ? WIN_BASE_MASKED : WIN_BASE_CLEAR;
   endfunction
endpackage

// File: rtl/alias_ctl_decode.sv
module alias_ctl_decode
   import alias_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W  = 20,
   parameter int unsigned VARIANT = 0
) (
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   output alias_op_e         op,
   output logic              rd_direct,
   output logic              undecoded
);
   localparam int unsigned OFF_W = ADDR_W - 3;
   localparam logic [OFF_W-1:0] BASE_OFF = OFF_W'(win_base(VARIANT));

   logic [OFF_W-1:0] off;
   logic             aligned;
   logic             hit_load, hit_alias1, hit_or;
   alias_op_e        alias1_op;

   assign off     = addr[ADDR_W-1:3];
   assign aligned = (addr[2:0] == 3'b000);

   assign hit_load   = aligned && (off == BASE_OFF);
   assign hit_alias1 = aligned && (off == BASE_OFF + OFF_W'(1));
   assign hit_or     = aligned && (off == BASE_OFF + OFF_W'(2));

   generate
      if (VARIANT == 0) begin : g_mask_alias
         assign alias1_op = OP_AND;
      end else begin : g_clear_alias
         assign alias1_op = OP_CLEAR;
      end
   endgenerate

   always_comb begin
      op = OP_NONE;
      if (req && we) begin
         if (hit_load)        op = OP_LOAD;
         else if (hit_alias1) op = alias1_op;
         else if (hit_or)     op = OP_OR;
      end
   end

   assign rd_direct = req && !we && hit_load;
   assign undecoded = req && !(hit_load || hit_alias1 || hit_or);
endmodule

// File: rtl/alias_ctl_next.sv
module alias_ctl_next
   import alias_ctl_pkg::*;
#(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned IMPL_BITS = 19,
   parameter int unsigned IRQ_POS   = 0,
   parameter int unsigned MSG_POS   = 3
) (
   input  alias_op_e         op,
   input  logic [DATA_W-1:0] cur,
   input  logic [DATA_W-1:0] wdata,
   input  logic              raise,
   output logic [DATA_W-1:0] nxt
);
   localparam logic [DATA_W-1:0] ONE   = {{(DATA_W-1){1'b0}}, 1'b1};
   localparam logic [DATA_W-1:0] KEEP  = ~({DATA_W{1'b1}} >> IMPL_BITS);
   localparam logic [DATA_W-1:0] RAISE = (ONE << (DATA_W-1-IRQ_POS)) |
                                         (ONE << (DATA_W-1-MSG_POS));

   logic [DATA_W-1:0] pre;

   always_comb begin
      case (op)
         OP_LOAD:  pre = wdata;
         OP_AND:   pre = cur & wdata;
         OP_OR:    pre = cur | wdata;
         OP_CLEAR: pre = '0;
         default:  pre = cur;
      endcase
      if (raise) pre = pre | RAISE;
      nxt = pre & KEEP;
   end
endmodule

// File: rtl/alias_ctl_reg.sv
module alias_ctl_reg
   import alias_ctl_pkg::*;
#(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned IMPL_BITS = 19,
   parameter int unsigned IRQ_POS   = 0,
   parameter int unsigned MSG_POS   = 3,
   parameter int unsigned VARIANT   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              raise_msg,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_level,
   output logic              bad_access
);
   localparam int unsigned IRQ_BIT = DATA_W - 1 - IRQ_POS;

   generate
      if (IMPL_BITS == 0 || IMPL_BITS > DATA_W) begin : g_bad_impl
         $error("IMPL_BITS must be in 1..DATA_W");
      end
      if (IRQ_POS >= IMPL_BITS || MSG_POS >= IMPL_BITS) begin : g_bad_pos
         $error("interrupt and message bits must be implemented bits");
      end
      if (VARIANT > 1) begin : g_bad_variant
         $error("VARIANT must be 0 or 1");
      end
      if (ADDR_W < 18) begin : g_bad_addr
         $error("ADDR_W too small for the register window");
      end
   endgenerate

   alias_op_e         op;
   logic              rd_direct, undecoded;
   logic [DATA_W-1:0] word_q, word_d;

   alias_ctl_decode #(.ADDR_W(ADDR_W), .VARIANT(VARIANT)) u_dec (
      .req       (bus_req),
      .we        (bus_we),
      .addr      (bus_addr),
      .op        (op),
      .rd_direct (rd_direct),
      .undecoded (undecoded)
   );

   alias_ctl_next #(
      .DATA_W(DATA_W), .IMPL_BITS(IMPL_BITS), .IRQ_POS(IRQ_POS), .MSG_POS(MSG_POS)
   ) u_next (
      .op    (op),
      .cur   (word_q),
      .wdata (bus_wdata),
      .raise (raise_msg),
      .nxt   (word_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q     <= '0;
         rd_data    <= '0;
         bad_access <= 1'b0;
      end else begin
         word_q     <= word_d;
         bad_access <= undecoded;
         if (bus_req && !bus_we) rd_data <= rd_direct ? word_q : '0;
      end
   end

   assign irq_level = word_q[IRQ_BIT];
endmodule

// File: rtl/alias_ctl_chk.sv
module alias_ctl_chk
   import alias_ctl_pkg::*;
#(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned IMPL_BITS = 19,
   parameter int unsigned VARIANT   = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              wdata_msb,
   input logic              raise_msg,
   input logic [DATA_W-1:0] rd_data,
   input logic              irq_level,
   input logic              bad_access
);
   localparam int unsigned OFF_W = ADDR_W - 3;
   localparam logic [OFF_W-1:0] B0 = OFF_W'(win_base(VARIANT));
   localparam logic [DATA_W-1:0] LOW = {DATA_W{1'b1}} >> IMPL_BITS;

   logic [OFF_W-1:0] off;
   logic al, in_win, at1, at2;
   assign off    = bus_addr[ADDR_W-1:3];
   assign al     = (bus_addr[2:0] == 3'b000);
   assign at1    = al && (off == B0 + OFF_W'(1));
   assign at2    = al && (off == B0 + OFF_W'(2));
   assign in_win = (al && off == B0) || at1 || at2;

   a_r3_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & LOW) == '0);
   a_r7_raise_irq: assert property (@(posedge clk) disable iff (!rst_n)
      raise_msg |=> irq_level);
   a_r6_or_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && at2 && wdata_msb) |=> irq_level);
   a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_req && !raise_msg) |=> $stable(irq_level));
   a_r5_alias1_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && at1 && !raise_msg && (VARIANT != 0 || !wdata_msb))
      |=> !irq_level);
   a_r9_alias_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && (at1 || at2)) |=> rd_data == '0);
   a_r10_bad_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !in_win) |=> bad_access);
   a_r10_no_bad: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_req || in_win) |=> !bad_access);
endmodule

bind alias_ctl_reg alias_ctl_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMPL_BITS(IMPL_BITS), .VARIANT(VARIANT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_req    (bus_req),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .wdata_msb  (bus_wdata[DATA_W-1]),
   .raise_msg  (raise_msg),
   .rd_data    (rd_data),
   .irq_level  (irq_level),
   .bad_access (bad_access)
);

// File: tb/tb_alias_ctl_reg.sv
`timescale 1ns/1ps
module tb_alias_ctl_reg;
   localparam logic [63:0] KEEP  = 64'hFFFF_E000_0000_0000;
   localparam logic [63:0] RBITS = 64'h9000_0000_0000_0000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_req = 1'b0, bus_we = 1'b0, raise_msg = 1'b0;
   logic [19:0] bus_addr = '0;
   logic [63:0] bus_wdata = '0;
   logic [63:0] rd_a, rd_b;
   logic irq_a, irq_b, bad_a, bad_b;
   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   alias_ctl_reg #(.VARIANT(0)) dut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .raise_msg(raise_msg),
      .rd_data(rd_a), .irq_level(irq_a), .bad_access(bad_a));

   alias_ctl_reg #(.VARIANT(1)) dut_b (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .raise_msg(raise_msg),
      .rd_data(rd_b), .irq_level(irq_b), .bad_access(bad_b));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one access cycle; outputs are valid at the returning negedge
   task automatic access(input logic we, input logic [16:0] off, input logic [2:0] lo,
                         input logic [63:0] d, input logic rz);
      @(negedge clk);
      bus_req = 1'b1; bus_we = we; bus_addr = {off, lo}; bus_wdata = d; raise_msg = rz;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0; raise_msg = 1'b0;
   endtask

   task automatic wr(input logic [16:0] off, input logic [63:0] d);
      access(1'b1, off, 3'b0, d, 1'b0);
   endtask

   task automatic rd(input logic [16:0] off);
      access(1'b0, off, 3'b0, 64'h0, 1'b0);
   endtask

   task automatic t_reset;
      chk("R1 irq after reset", {63'h0, irq_a}, 64'h0);
      chk("R1 bad after reset", {63'h0, bad_a}, 64'h0);
      chk("R1 rd_data after reset", rd_a, 64'h0);
      rd(17'h4020);
      chk("R1 word after reset", rd_a, 64'h0);
   endtask

   task automatic t_direct;
      wr(17'h4020, 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R6 irq after direct write", {63'h0, irq_a}, 64'h1);
      rd(17'h4020);
      chk("R2 R3 direct readback masked", rd_a, KEEP);
      chk("R10 no pulse on decoded read", {63'h0, bad_a}, 64'h0);
   endtask

   task automatic t_and_or;
      wr(17'h4021, 64'h7FFF_0000_0000_0000);
      chk("R6 irq cleared by AND", {63'h0, irq_a}, 64'h0);
      rd(17'h4020);
      chk("R4 AND alias", rd_a, 64'h7FFF_0000_0000_0000);
      wr(17'h4022, 64'h8000_0000_0000_0001);
      chk("R6 irq set by OR", {63'h0, irq_a}, 64'h1);
      rd(17'h4020);
      chk("R4 OR alias", rd_a, 64'hFFFF_0000_0000_0000);
      rd(17'h4022);
      chk("R9 alias read zero", rd_a, 64'h0);
   endtask

   task automatic t_raise;
      wr(17'h4020, 64'h0);
      @(negedge clk); raise_msg = 1'b1;
      @(negedge clk); raise_msg = 1'b0;
      chk("R7 raise sets irq", {63'h0, irq_a}, 64'h1);
      rd(17'h4020);
      chk("R7 raise bits", rd_a, RBITS);
   endtask

   task automatic t_same_cycle;
      access(1'b1, 17'h4020, 3'b0, 64'h0400_0000_0000_0000, 1'b1);
      rd(17'h4020);
      chk("R8 load then raise", rd_a, 64'h9400_0000_0000_0000);
      access(1'b1, 17'h4021, 3'b0, 64'h0, 1'b1);
      rd(17'h4020);
      chk("R8 AND zero then raise", rd_a, RBITS);
   endtask

   task automatic t_undecoded;
      wr(17'h4020, 64'h1234_5000_0000_0000);
      access(1'b1, 17'h4023, 3'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
      chk("R10 pulse on undecoded write", {63'h0, bad_a}, 64'h1);
      @(negedge clk);
      chk("R10 pulse lasts one cycle", {63'h0, bad_a}, 64'h0);
      access(1'b1, 17'h6080, 3'b0, 64'h0, 1'b0);
      access(1'b1, 17'h4020, 3'b100, 64'h0, 1'b0);
      chk("R10 pulse on misaligned", {63'h0, bad_a}, 64'h1);
      rd(17'h4020);
      chk("R9 undecoded writes ignored", rd_a, 64'h1234_4000_0000_0000);
      rd(17'h4100);
      chk("R9 undecoded read zero", rd_a, 64'h0);
   endtask

   task automatic t_variant_b;
      wr(17'h6080, 64'hA5A5_A5A5_A5A5_A5A5);
      rd(17'h6080);
      chk("R5 variant B direct", rd_b, 64'hA5A5_A000_0000_0000);
      chk("R5 variant B irq", {63'h0, irq_b}, 64'h1);
      wr(17'h6081, 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R5 clear drops irq", {63'h0, irq_b}, 64'h0);
      rd(17'h6080);
      chk("R5 clear ignores data", rd_b, 64'h0);
      wr(17'h6082, 64'h0800_0000_0000_0000);
      wr(17'h6082, 64'h0010_0000_0000_0000);
      rd(17'h6080);
      chk("R5 variant B OR", rd_b, 64'h0810_0000_0000_0000);
      access(1'b1, 17'h4021, 3'b0, 64'h0, 1'b0);
      chk("R10 variant A alias undecoded on B", {63'h0, bad_b}, 64'h1);
      rd(17'h6080);
      chk("R9 variant B unchanged", rd_b, 64'h0810_0000_0000_0000);
   endtask

   initial begin
      #(200000 * 8);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direct();
      t_and_or();
      t_raise();
      t_same_cycle();
      t_undecoded();
      t_variant_b();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule